// File: doc/BRIEF.md
# Paged Write Cache with Deferred Commit

This block collects the data bytes of one multi-byte write in a 64-byte cache and programs the memory array only after the transaction closes. The bus front end opens a transaction with a 13-bit word address, then delivers bytes one at a time. Each byte goes to a cache slot chosen by a six-bit offset pointer. The pointer starts at the low six bits of the address and steps by one per byte. The cache is built as eight lines of eight bytes. The pointer moves across line boundaries, but it wraps around inside the 64-byte window and never crosses into the next one.

When the front end signals Stop, the block walks all 64 offsets in ascending order, one per cycle. For every slot that was filled in this transaction, it issues a write strobe to the array. The array address is formed from the seven fixed upper address bits and the slot offset. After the scan, a programming delay of a set number of cycles follows. Busy stays high for the whole scan and delay. Any request that arrives while busy is refused. An abort closes the transaction and discards the cache without writing anything.

Top module: `page_cache_commit`

## Requirements
- R1: After reset, `busy_o` and `arr_we_o` are low and no transaction is open.
- R2: When `busy_o` is low, `wr_start_i` opens a transaction. The upper seven bits of `wr_addr_i` are kept as the window base, and the first byte lands at offset `wr_addr_i[5:0]`.
- R3: Each accepted byte advances only the six-bit offset, by one. When the offset leaves the last byte of an eight-byte line (`offset[2:0]` = 7), the line number (`offset[5:3]`) advances by one. The upper seven address bits never change.
- R4: After offset 63 the pointer wraps to offset 0. When more than 64 bytes arrive, later bytes overwrite the earlier ones in the same slots.
- R5: A Stop in an open transaction starts the commit on the next cycle. Offsets 0 to 63 are scanned one per cycle in ascending order. `arr_we_o` pulses only for slots filled in this transaction. Each pulse carries `arr_addr_o` = {base, offset} and the last byte stored at that offset.
- R6: `busy_o` rises the cycle after the accepted Stop and stays high for exactly 64 + `PROG_CYCLES` cycles.
- R7: An abort in an open transaction closes it. No write occurs and `busy_o` stays low.
- R8: While `busy_o` is high, start, data, Stop and abort inputs have no effect.
- R9: The fill flags are cleared when each transaction opens, so a commit writes only the bytes of its own transaction.
- R10: When no transaction is open, data, Stop and abort are ignored. In an open transaction, the priority is start, then abort, then Stop, then data. A byte presented in the same cycle as any of the higher-priority inputs is dropped.
- R11: A start inside an open transaction discards the uncommitted bytes and reopens the transaction at the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start_i | input | 1 | Open a write transaction |
| wr_addr_i | input | 13 | Starting word address, sampled with start |
| byte_valid_i | input | 1 | A data byte is presented |
| byte_data_i | input | 8 | Data byte |
| stop_i | input | 1 | Close the transaction and commit |
| abort_i | input | 1 | Close the transaction and discard |
| busy_o | output | 1 | Commit scan or programming delay in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | 13 | Array write address |
| arr_data_o | output | 8 | Array write data |

## Verification
A bad offset pointer or a bad line step does not show at the ports during capture. It shows only after Stop, as a wrong `arr_addr_o`/`arr_data_o` pair or as a missing strobe at the scan cycle of that offset. That can be up to 64 cycles after the Stop. Stale fill flags show as extra strobes during the next commit. Errors in busy or acceptance logic show within one cycle as a `busy_o` mismatch. The bench therefore compares every output on every cycle against a behavioural model, so each such fault is reported in the exact cycle where it appears.

// File: rtl/pcache_pkg.sv
package pcache_pkg;
  typedef enum logic [1:0] {
    CM_IDLE = 2'd0,
    CM_SCAN = 2'd1,
    CM_PROG = 2'd2
  } commit_state_e;
endpackage

// File: rtl/pcache_ptr.sv
module pcache_ptr #(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 3,
  parameter int LINE_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic                         step_i,
  output logic [ADDR_W-COL_W-LINE_W-1:0] base_o,
  output logic [COL_W+LINE_W-1:0]      off_o
);
  localparam int OFF_W  = COL_W + LINE_W;
  localparam int BASE_W = ADDR_W - OFF_W;

  function automatic logic [OFF_W-1:0] advance(input logic [OFF_W-1:0] o);
    return o + OFF_W'(1);
  endfunction

  logic [BASE_W-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic [COL_W-1:0]  col_w;
  logic [LINE_W-1:0] line_w;
  logic              line_cross_w;

  assign col_w        = off_q[COL_W-1:0];
  assign line_w       = off_q[OFF_W-1:COL_W];
  assign line_cross_w = step_i && !load_i && (col_w == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      base_q <= addr_i[ADDR_W-1:OFF_W];
      off_q  <= addr_i[OFF_W-1:0];
    end else if (step_i) begin
      off_q  <= advance(off_q);
    end
  end

  assign base_o = base_q;
  assign off_o  = off_q;

  // R3
  off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !load_i |=> off_q == OFF_W'($past(off_q) + 1'b1));
  // R3
  line_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_cross_w |=> (col_w == '0) && (line_w == LINE_W'($past(line_w) + 1'b1)));
  // R3
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(base_q));
endmodule

// File: rtl/pcache_store.sv
module pcache_store #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_hit_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (clr_i) begin
      fill_q <= '0;
    end else if (wr_i) begin
      fill_q[wr_idx_i] <= 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem_q[g] <= '0;
        else if (wr_i && !clr_i && (wr_idx_i == IDX_W'(g)))
          mem_q[g] <= wr_data_i;
      end
    end
  endgenerate

  assign rd_data_o = mem_q[rd_idx_i];
  assign rd_hit_o  = fill_q[rd_idx_i];

  // R9
  fill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> $countones(fill_q) == 0);
  // R5
  fill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && !clr_i |=> fill_q[$past(wr_idx_i)]);
endmodule

// File: rtl/pcache_commit.sv
module pcache_commit
  import pcache_pkg::*;
#(
  parameter int IDX_W       = 6,
  parameter int PROG_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             hit_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             we_o,
  output logic             busy_o
);
  localparam int CNT_W = (PROG_CYCLES < 2) ? 1 : $clog2(PROG_CYCLES);

  commit_state_e     state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              scan_last_w;
  logic              prog_last_w;

  assign scan_last_w = (idx_q == '1);
  assign prog_last_w = (cnt_q == CNT_W'(PROG_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CM_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        CM_IDLE: if (go_i) begin
          state_q <= CM_SCAN;
          idx_q   <= '0;
        end
        CM_SCAN: if (scan_last_w) begin
          state_q <= CM_PROG;
          cnt_q   <= '0;
        end else begin
          idx_q   <= idx_q + IDX_W'(1);
        end
        CM_PROG: if (prog_last_w) state_q <= CM_IDLE;
                 else cnt_q <= cnt_q + CNT_W'(1);
        default: state_q <= CM_IDLE;
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign we_o   = (state_q == CM_SCAN) && hit_i;
  assign busy_o = (state_q != CM_IDLE);

  // R5
  scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CM_SCAN) && !scan_last_w |=> idx_q == IDX_W'($past(idx_q) + 1'b1));
  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(state_q) == CM_PROG);
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> idx_q == '0);
endmodule

// File: rtl/page_cache_commit.sv
module page_cache_commit #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int COL_W       = 3,
  parameter int LINE_W      = 3,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              stop_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o
);
  localparam int OFF_W  = COL_W + LINE_W;
  localparam int BASE_W = ADDR_W - OFF_W;

  logic              open_q;
  logic              busy_w;
  logic              start_acc_w, abort_acc_w, stop_acc_w, byte_acc_w;
  logic [BASE_W-1:0] base_w;
  logic [OFF_W-1:0]  off_w;
  logic [OFF_W-1:0]  scan_idx_w;
  logic              hit_w;
  logic              we_w;
  logic [DATA_W-1:0] rd_data_w;

  assign start_acc_w = wr_start_i && !busy_w;
  assign abort_acc_w = open_q && !wr_start_i && abort_i;
  assign stop_acc_w  = open_q && !wr_start_i && !abort_i && stop_i;
  assign byte_acc_w  = open_q && !wr_start_i && !abort_i && !stop_i && byte_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          open_q <= 1'b0;
    else if (start_acc_w)                open_q <= 1'b1;
    else if (abort_acc_w || stop_acc_w)  open_q <= 1'b0;
  end

  pcache_ptr #(.ADDR_W(ADDR_W), .COL_W(COL_W), .LINE_W(LINE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(start_acc_w), .addr_i(wr_addr_i),
    .step_i(byte_acc_w), .base_o(base_w), .off_o(off_w)
  );

  pcache_store #(.DATA_W(DATA_W), .IDX_W(OFF_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_i(start_acc_w || abort_acc_w),
    .wr_i(byte_acc_w), .wr_idx_i(off_w), .wr_data_i(byte_data_i),
    .rd_idx_i(scan_idx_w), .rd_data_o(rd_data_w), .rd_hit_o(hit_w)
  );

  pcache_commit #(.IDX_W(OFF_W), .PROG_CYCLES(PROG_CYCLES)) u_commit (
    .clk(clk), .rst_n(rst_n), .go_i(stop_acc_w), .hit_i(hit_w),
    .idx_o(scan_idx_w), .we_o(we_w), .busy_o(busy_w)
  );

  assign busy_o     = busy_w;
  assign arr_we_o   = we_w;
  assign arr_addr_o = {base_w, scan_idx_w};
  assign arr_data_o = rd_data_w;

  // R5
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o);
  // R7
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_acc_w |=> !busy_o && !arr_we_o && !open_q);
  // R8
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !open_q);
  // R6
  stop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_acc_w |=> busy_o);
endmodule

// File: tb/sim_page_cache_commit.sv
module sim_page_cache_commit;
  localparam int PROG = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st = 1'b0, dv = 1'b0, sp = 1'b0, ab = 1'b0;
  logic [12:0] ad = '0;
  logic [7:0]  dt = '0;
  logic busy, we;
  logic [12:0] waddr;
  logic [7:0]  wdata;

  always #4 clk = ~clk;

  page_cache_commit #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_start_i(st), .wr_addr_i(ad),
    .byte_valid_i(dv), .byte_data_i(dt), .stop_i(sp), .abort_i(ab),
    .busy_o(busy), .arr_we_o(we), .arr_addr_o(waddr), .arr_data_o(wdata)
  );

  int checks = 0, fails = 0, wecnt = 0, busycnt = 0;
  bit done = 0;
  logic [7:0] ram [8192];

  // behavioural model
  int m_phase = 0;  // 0 free, 2 scanning, 3 programming
  bit m_open = 0;
  int m_base = 0, m_off = 0, m_idx = 0, m_cnt = 0;
  int m_cache [64];
  bit m_fill [64];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (we) begin ram[waddr] <= wdata; wecnt++; end
    if (busy) busycnt++;
    if (!rst_n) begin
      m_phase = 0; m_open = 0; m_off = 0; m_base = 0;
      foreach (m_fill[i]) m_fill[i] = 0;
    end else if (m_phase == 2) begin
      if (m_idx == 63) begin m_phase = 3; m_cnt = 0; end else m_idx++;
    end else if (m_phase == 3) begin
      if (m_cnt == PROG - 1) m_phase = 0; else m_cnt++;
    end else if (st) begin
      m_open = 1; m_base = int'(ad) / 64; m_off = int'(ad) % 64;
      foreach (m_fill[i]) m_fill[i] = 0;
    end else if (m_open) begin
      if (ab) begin m_open = 0; foreach (m_fill[i]) m_fill[i] = 0; end
      else if (sp) begin m_open = 0; m_phase = 2; m_idx = 0; end
      else if (dv) begin
        m_cache[m_off] = int'(dt); m_fill[m_off] = 1; m_off = (m_off + 1) % 64;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ewe;
      ewe = (m_phase == 2) && m_fill[m_idx];
      check(busy == (m_phase >= 2), "R6", "busy", int'(busy), int'(m_phase >= 2));
      check(we == ewe, "R5", "write strobe", int'(we), int'(ewe));
      if (we && ewe) begin
        check(int'(waddr) == m_base * 64 + m_idx, "R5", "write address",
              int'(waddr), m_base * 64 + m_idx);
        check(int'(wdata) == m_cache[m_idx], "R5", "write data",
              int'(wdata), m_cache[m_idx]);
      end
    end
  end

  task automatic drive(bit s, int a, bit v, int d, bit p, bit b);
    @(negedge clk);
    st = s; ad = 13'(a); dv = v; dt = 8'(d); sp = p; ab = b;
  endtask
  task automatic idle1(); drive(0, 0, 0, 0, 0, 0); endtask
  task automatic wait_free();
    idle1();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    foreach (ram[i]) ram[i] = 8'hEE;
    repeat (3) @(negedge clk);
    check(busy == 0 && we == 0, "R1", "reset outputs", int'({busy, we}), 0);
    rst_n = 1'b1;
    idle1();
    check(busy == 0, "R1", "idle after reset", int'(busy), 0);

    // R2 R3 wrap inside window: 0x1A3D, 5 bytes -> offsets 61..63,0,1
    drive(1, 'h1A3D, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) drive(0, 0, 1, 'h50 + i, 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    wecnt = 0; busycnt = 0;
    wait_free();
    check(ram['h1A3D] == 8'h50, "R2", "first byte slot", ram['h1A3D], 'h50);
    check(ram['h1A00] == 8'h53, "R3", "window wrap", ram['h1A00], 'h53);
    check(ram['h1A40] == 8'hEE, "R3", "next window untouched", ram['h1A40], 'hEE);
    check(busycnt == 64 + PROG, "R6", "busy length", busycnt, 64 + PROG);
    check(wecnt == 5, "R5", "strobe count", wecnt, 5);

    // R3 line crossing: 0x0205, 4 bytes -> offsets 5..8
    drive(1, 'h0205, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 'h60 + i, 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    wait_free();
    check(ram['h0208] == 8'h63, "R3", "line cross", ram['h0208], 'h63);

    // R4 overflow: 70 bytes at 0x0100
    drive(1, 'h0100, 0, 0, 0, 0);
    for (int i = 0; i < 70; i++) drive(0, 0, 1, i, 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    wecnt = 0;
    wait_free();
    check(ram['h0100] == 8'd64, "R4", "overwrite slot0", ram['h0100], 64);
    check(ram['h0105] == 8'd69, "R4", "overwrite slot5", ram['h0105], 69);
    check(ram['h0106] == 8'd6, "R4", "kept slot6", ram['h0106], 6);
    check(wecnt == 64, "R4", "full scan strobes", wecnt, 64);

    // R7 abort
    drive(1, 'h0300, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 'h70 + i, 0, 0);
    drive(0, 0, 0, 0, 0, 1);
    wecnt = 0;
    idle1(); idle1();
    check(busy == 0, "R7", "no busy after abort", int'(busy), 0);
    drive(0, 0, 0, 0, 1, 0);
    repeat (80) idle1();
    check(wecnt == 0, "R7", "no writes after abort", wecnt, 0);
    check(ram['h0300] == 8'hEE, "R7", "array untouched", ram['h0300], 'hEE);

    // R8 refuse while busy
    drive(1, 'h0410, 0, 0, 0, 0);
    drive(0, 0, 1, 'hA1, 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    drive(1, 'h0400, 0, 0, 0, 0);
    drive(0, 0, 1, 'hB1, 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    wecnt = 0;
    wait_free();
    repeat (80) idle1();
    check(ram['h0400] == 8'hEE, "R8", "busy start ignored", ram['h0400], 'hEE);
    check(wecnt == 1, "R8", "single commit", wecnt, 1);

    // R9 flags cleared: reuse window 0x0500
    drive(1, 'h0500, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 'hC0 + i, 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    wait_free();
    drive(1, 'h050A, 0, 0, 0, 0);
    drive(0, 0, 1, 'hCA, 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    wecnt = 0;
    wait_free();
    check(wecnt == 1, "R9", "only new byte committed", wecnt, 1);

    // R10 idle inputs ignored; byte with stop dropped
    drive(0, 0, 1, 'h99, 1, 0);
    idle1();
    check(busy == 0, "R10", "stop without txn", int'(busy), 0);
    drive(1, 'h0600, 0, 0, 0, 0);
    drive(0, 0, 1, 'h11, 0, 0);
    drive(0, 0, 1, 'h22, 1, 1);
    idle1();
    check(busy == 0, "R10", "abort beats stop", int'(busy), 0);
    drive(1, 'h0600, 0, 0, 0, 0);
    drive(0, 0, 1, 'h11, 0, 0);
    drive(0, 0, 1, 'h22, 1, 0);
    wecnt = 0;
    wait_free();
    check(wecnt == 1, "R10", "byte with stop dropped", wecnt, 1);
    check(ram['h0601] == 8'hEE, "R10", "dropped slot", ram['h0601], 'hEE);

    // R11 restart inside open txn
    drive(1, 'h0700, 0, 0, 0, 0);
    drive(0, 0, 1, 'h31, 0, 0);
    drive(0, 0, 1, 'h32, 0, 0);
    drive(1, 'h0740, 1, 'h3F, 0, 0);
    drive(0, 0, 1, 'h33, 0, 0);
    drive(0, 0, 0, 0, 1, 0);
    wait_free();
    check(ram['h0700] == 8'hEE, "R11", "old bytes discarded", ram['h0700], 'hEE);
    check(ram['h0740] == 8'h33, "R11", "new base", ram['h0740], 'h33);

    idle1();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule